// File: doc/BRIEF.md
# Multi-Stream Command Dispatcher

This block accepts commands one at a time, in the order they are issued. Each command carries a stream number and a kind: a compute job, a host-to-device copy or a device-to-host copy. Compute jobs go into a compute queue and both kinds of copy go into a copy queue. Each queue hands out commands strictly in order. The queue head is sent to an execution slot once its stream ordering is met and a slot of the right kind is free. Every dispatch carries a tag that names the slot. The execution engines report a finished command by returning that tag.

Commands in the same stream run one after another, while commands in different streams may overlap. Stream 0 acts as a global barrier. A command on stream 0 waits until every earlier command has finished, and no later command starts until it has finished. A queue head that cannot go holds back every later command in its queue, whatever their streams. Up to sixteen compute jobs can run at once. There is one copy slot for each direction, so one copy of each direction can run alongside the compute work.

Top module: `stream_dispatch`

## Requirements
- R1: After reset both queues are empty, `in_ready` is high for every kind and neither `cmp_go` nor `cpy_go` is asserted.
- R2: `in_kind` is encoded as 0 = compute, 1 = host-to-device copy and 2 = device-to-host copy. `in_ready` is high exactly when the target queue (compute for kind 0, copy for kinds 1 and 2) holds fewer than 8 commands, and a command is accepted on a cycle where `in_valid` and `in_ready` are both high.
- R3: Each queue dispatches its commands in acceptance order. A head that cannot dispatch blocks every later command of that queue, including commands on other streams.
- R4: A command on a non-zero stream dispatches only after every earlier-accepted command of the same stream has completed.
- R5: A command on stream 0 dispatches only after every earlier-accepted command of every stream has completed. A later command of any stream dispatches only after every earlier stream-0 command has completed.
- R6: At most 16 compute jobs are in flight. Each dispatched compute job receives the lowest-numbered free compute tag, in the range 0 to 15.
- R7: A host-to-device copy uses tag 16 and a device-to-host copy uses tag 17, so at most one copy of each direction is in flight. Copies of the two directions may run concurrently with each other and with compute jobs.
- R8: A queue head dispatches in the first cycle in which all of its conditions hold. The earliest such cycle is the one after it was accepted, or the one after the completion that freed it.
- R9: A completion (`done_valid` with `done_tag`) frees that slot and credits the command's stream from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A command is offered |
| in_kind | input | 2 | Command kind (0 compute, 1 host-to-device, 2 device-to-host) |
| in_stream | input | 5 | Stream number of the offered command |
| in_ready | output | 1 | The target queue has room |
| cmp_go | output | 1 | A compute job is dispatched this cycle |
| cmp_tag | output | 5 | Slot tag of the dispatched compute job |
| cmp_stream | output | 5 | Stream of the dispatched compute job |
| cpy_go | output | 1 | A copy is dispatched this cycle |
| cpy_tag | output | 5 | Slot tag of the copy (16 or 17) |
| cpy_stream | output | 5 | Stream of the dispatched copy |
| done_valid | input | 1 | A dispatched command has finished |
| done_tag | input | 5 | Tag of the finished command |

## Verification
The assertions assume three things about the inputs. `in_kind` never takes the reserved value 3, at most one completion arrives per cycle, and `done_tag` always names a slot that is currently busy. The stimulus draws kinds only from 0 to 2. It returns a completion only for a tag that the bench itself has recorded as dispatched and not yet finished, and it returns at most one per cycle. Stream and kind mixes differ from phase to phase so that both the barrier and the per-type blocking get exercised.

// File: rtl/disp_pkg.sv
package disp_pkg;
   localparam logic [1:0] KIND_CMP = 2'd0;
   localparam logic [1:0] KIND_H2D = 2'd1;
   localparam logic [1:0] KIND_D2H = 2'd2;
endpackage

// File: rtl/disp_fifo.sv
module disp_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("disp_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0] mem [DEPTH];
   logic [AW-1:0] rd_ptr, wr_ptr;
   logic [AW:0]   fill;

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         fill   <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         fill <= fill + (AW+1)'(push) - (AW+1)'(pop);
      end
   end

   assign dout  = mem[rd_ptr];
   assign full  = (fill == (AW+1)'(DEPTH));
   assign empty = (fill == '0);

   // R2: the issue side never writes into a full queue
   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R3: a dispatch only ever takes an existing head
   a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/disp_gate.sv
module disp_gate #(
   parameter int SID_W = 5,
   parameter int CW    = 8
) (
   input  logic [SID_W-1:0] sid,
   input  logic [CW-1:0]    sseq,
   input  logic [CW-1:0]    zseq,
   input  logic [CW-1:0]    gseq,
   input  logic [CW-1:0]    s_done,
   input  logic [CW-1:0]    z_done,
   input  logic [CW-1:0]    g_done,
   output logic             ok
);
   always_comb begin
      if (sid == '0) ok = (g_done == gseq);
      else           ok = (s_done == sseq) && (z_done == zseq);
   end
endmodule

// File: rtl/disp_slots.sv
module disp_slots #(
   parameter int NCMP  = 16,
   parameter int SID_W = 5,
   parameter int TAG_W = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   c_alloc,
   input  logic [SID_W-1:0]       c_sid,
   input  logic                   x_alloc,
   input  logic [TAG_W-1:0]       x_tag,
   input  logic [SID_W-1:0]       x_sid,
   input  logic                   rel,
   input  logic [TAG_W-1:0]       rel_tag,
   output logic                   c_any,
   output logic [TAG_W-1:0]       c_idx,
   output logic [NCMP+1:0]        busy,
   output logic [SID_W-1:0]       rel_sid
);
   localparam int NSLOT = NCMP + 2;

   logic [SID_W-1:0] own_arr [NSLOT];

   always_comb begin
      c_any = 1'b0;
      c_idx = '0;
      for (int i = NCMP - 1; i >= 0; i--) begin
         if (!busy[i]) begin
            c_any = 1'b1;
            c_idx = TAG_W'(i);
         end
      end
   end

   generate
      for (genvar s = 0; s < NSLOT; s++) begin : g_slot
         localparam bit IS_CMP = (s < NCMP);
         logic             b_q;
         logic [SID_W-1:0] o_q;
         logic             set;
         logic             clr;
         if (IS_CMP) begin : g_c
            assign set = c_alloc && (c_idx == TAG_W'(s));
         end else begin : g_x
            assign set = x_alloc && (x_tag == TAG_W'(s));
         end
         assign clr = rel && (rel_tag == TAG_W'(s));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               b_q <= 1'b0;
               o_q <= '0;
            end else if (set) begin
               b_q <= 1'b1;
               o_q <= IS_CMP ? c_sid : x_sid;
            end else if (clr) begin
               b_q <= 1'b0;
            end
         end
         assign busy[s]    = b_q;
         assign own_arr[s] = o_q;
      end
   endgenerate

   always_comb begin
      rel_sid = '0;
      for (int s = 0; s < NSLOT; s++)
         if (rel_tag == TAG_W'(s)) rel_sid = own_arr[s];
   end

   // R9: completions only name a slot that is in flight
   a_r9_release_busy: assert property (@(posedge clk) disable iff (!rst_n)
      rel |-> busy[rel_tag]);
   // R7: a copy slot is never granted twice
   a_r7_copy_free: assert property (@(posedge clk) disable iff (!rst_n)
      x_alloc |-> !busy[x_tag]);
endmodule

// File: rtl/stream_dispatch.sv
module stream_dispatch #(
   parameter int NSTREAM = 32,
   parameter int NCMP    = 16,
   parameter int QDEPTH  = 8,
   parameter int CW      = 8,
   localparam int SID_W  = $clog2(NSTREAM),
   localparam int TAG_W  = $clog2(NCMP + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [1:0]       in_kind,
   input  logic [SID_W-1:0] in_stream,
   output logic             in_ready,
   output logic             cmp_go,
   output logic [TAG_W-1:0] cmp_tag,
   output logic [SID_W-1:0] cmp_stream,
   output logic             cpy_go,
   output logic [TAG_W-1:0] cpy_tag,
   output logic [SID_W-1:0] cpy_stream,
   input  logic             done_valid,
   input  logic [TAG_W-1:0] done_tag
);
   import disp_pkg::*;

   localparam int EW = 2 + SID_W + 3 * CW;

   generate
      if (NSTREAM < 2) begin : g_bad_ns
         $error("stream_dispatch: NSTREAM must be at least 2");
      end
      if ((1 << CW) <= 2 * QDEPTH + NCMP + 2) begin : g_bad_cw
         $error("stream_dispatch: CW too narrow for the outstanding window");
      end
   endgenerate

   // per-stream and global issue / completion counters
   logic [CW-1:0] iss_cnt  [NSTREAM];
   logic [CW-1:0] done_cnt [NSTREAM];
   logic [CW-1:0] g_iss, g_done;

   logic          to_copy, accept;
   logic          kq_full, kq_empty, cq_full, cq_empty;
   logic [EW-1:0] enq_word, kq_dout, cq_dout;

   assign to_copy  = (in_kind != KIND_CMP);
   assign in_ready = to_copy ? !cq_full : !kq_full;
   assign accept   = in_valid && in_ready;
   assign enq_word = {in_kind, in_stream, iss_cnt[in_stream], iss_cnt[0], g_iss};

   logic [1:0]       k_kind, x_kind;
   logic [SID_W-1:0] k_sid, x_sid;
   logic [CW-1:0]    k_sseq, k_zseq, k_gseq, x_sseq, x_zseq, x_gseq;
   assign {k_kind, k_sid, k_sseq, k_zseq, k_gseq} = kq_dout;
   assign {x_kind, x_sid, x_sseq, x_zseq, x_gseq} = cq_dout;

   disp_fifo #(.W(EW), .DEPTH(QDEPTH)) u_kq (
      .clk(clk), .rst_n(rst_n), .push(accept && !to_copy), .din(enq_word),
      .pop(cmp_go), .dout(kq_dout), .full(kq_full), .empty(kq_empty));

   disp_fifo #(.W(EW), .DEPTH(QDEPTH)) u_cq (
      .clk(clk), .rst_n(rst_n), .push(accept && to_copy), .din(enq_word),
      .pop(cpy_go), .dout(cq_dout), .full(cq_full), .empty(cq_empty));

   logic k_ok, x_ok;

   disp_gate #(.SID_W(SID_W), .CW(CW)) u_kgate (
      .sid(k_sid), .sseq(k_sseq), .zseq(k_zseq), .gseq(k_gseq),
      .s_done(done_cnt[k_sid]), .z_done(done_cnt[0]), .g_done(g_done), .ok(k_ok));

   disp_gate #(.SID_W(SID_W), .CW(CW)) u_xgate (
      .sid(x_sid), .sseq(x_sseq), .zseq(x_zseq), .gseq(x_gseq),
      .s_done(done_cnt[x_sid]), .z_done(done_cnt[0]), .g_done(g_done), .ok(x_ok));

   logic             c_any;
   logic [TAG_W-1:0] c_idx, x_tag;
   logic [NCMP+1:0]  busy;
   logic [SID_W-1:0] rel_sid;

   assign x_tag = (x_kind == KIND_H2D) ? TAG_W'(NCMP) : TAG_W'(NCMP + 1);

   disp_slots #(.NCMP(NCMP), .SID_W(SID_W), .TAG_W(TAG_W)) u_slots (
      .clk(clk), .rst_n(rst_n),
      .c_alloc(cmp_go), .c_sid(k_sid),
      .x_alloc(cpy_go), .x_tag(x_tag), .x_sid(x_sid),
      .rel(done_valid), .rel_tag(done_tag),
      .c_any(c_any), .c_idx(c_idx), .busy(busy), .rel_sid(rel_sid));

   assign cmp_go     = !kq_empty && k_ok && c_any;
   assign cmp_tag    = c_idx;
   assign cmp_stream = k_sid;
   assign cpy_go     = !cq_empty && x_ok && !busy[x_tag];
   assign cpy_tag    = x_tag;
   assign cpy_stream = x_sid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         g_iss  <= '0;
         g_done <= '0;
         for (int i = 0; i < NSTREAM; i++) begin
            iss_cnt[i]  <= '0;
            done_cnt[i] <= '0;
         end
      end else begin
         if (accept)     g_iss  <= g_iss + 1'b1;
         if (done_valid) g_done <= g_done + 1'b1;
         for (int i = 0; i < NSTREAM; i++) begin
            if (accept && in_stream == SID_W'(i))      iss_cnt[i]  <= iss_cnt[i] + 1'b1;
            if (done_valid && rel_sid == SID_W'(i))    done_cnt[i] <= done_cnt[i] + 1'b1;
         end
      end
   end

   // per-stream in-flight flags, kept apart from the counters to guard them
   logic [NSTREAM-1:0] run_flag;
   always_ff @(posedge clk) begin
      if (!rst_n) run_flag <= '0;
      else begin
         for (int i = 0; i < NSTREAM; i++) begin
            if (done_valid && rel_sid == SID_W'(i)) run_flag[i] <= 1'b0;
            if ((cmp_go && k_sid == SID_W'(i)) || (cpy_go && x_sid == SID_W'(i)))
               run_flag[i] <= 1'b1;
         end
      end
   end

   // R2: reserved kind never offered
   a_r2_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> in_kind != 2'b11);
   // R3: compute queue holds only compute jobs
   a_r3_kq_kind: assert property (@(posedge clk) disable iff (!rst_n)
      !kq_empty |-> k_kind == KIND_CMP);
   // R4: a stream never has two commands in flight
   a_r4_cmp_serial: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_go |-> !run_flag[cmp_stream]);
   a_r4_cpy_serial: assert property (@(posedge clk) disable iff (!rst_n)
      cpy_go |-> !run_flag[cpy_stream]);
   a_r4_no_twin: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_go && cpy_go) |-> cmp_stream != cpy_stream);
   // R5: stream 0 runs alone
   a_r5_barrier_alone: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmp_go && cmp_stream == '0) || (cpy_go && cpy_stream == '0)) |-> run_flag == '0);
   a_r5_barrier_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_go || cpy_go) |-> !run_flag[0]);
endmodule

// File: tb/stream_dispatch_test.sv
module stream_dispatch_test;
   localparam int CLK_P = 10;
   localparam int NS    = 32;
   localparam int NC    = 16;
   localparam int QD    = 8;
   localparam int NLOG  = 512;
   localparam int LIMIT = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid, in_ready, cmp_go, cpy_go, done_valid;
   logic [1:0] in_kind;
   logic [4:0] in_stream, cmp_tag, cmp_stream, cpy_tag, cpy_stream, done_tag;

   always #(CLK_P/2) clk = ~clk;

   stream_dispatch uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
      .in_stream(in_stream), .in_ready(in_ready), .cmp_go(cmp_go),
      .cmp_tag(cmp_tag), .cmp_stream(cmp_stream), .cpy_go(cpy_go),
      .cpy_tag(cpy_tag), .cpy_stream(cpy_stream), .done_valid(done_valid),
      .done_tag(done_tag));

   int checks = 0, errors = 0, cyc = 0, nlog = 0;
   bit hung = 0;
   int c_sid [NLOG];
   int c_kind[NLOG];
   int c_st  [NLOG];
   int owner [NC+2];
   int kq[$];
   int cq[$];

   always @(posedge clk) cyc++;

   // rule-level view of stream ordering (R4, R5)
   function automatic bit order_ok(int i);
      for (int j = 0; j < i; j++)
         if (c_st[j] != 2 && (c_sid[j] == c_sid[i] || c_sid[i] == 0 || c_sid[j] == 0))
            return 1'b0;
      return 1'b1;
   endfunction

   function automatic int cmp_running();
      int n = 0;
      for (int t = 0; t < NC; t++) if (owner[t] >= 0) n++;
      return n;
   endfunction

   function automatic int low_free();
      for (int t = 0; t < NC; t++) if (owner[t] < 0) return t;
      return -1;
   endfunction

   function automatic bit all_done();
      for (int i = 0; i < nlog; i++) if (c_st[i] != 2) return 1'b0;
      return 1'b1;
   endfunction

   task automatic step(input bit want, input int kind, input int sid, input int pct,
                       output bit took);
      bit exp_k, exp_x, exp_rdy;
      int ksz, csz, ct, cidx, h, xt;
      took = 1'b0;
      @(negedge clk);
      if (cyc > LIMIT) hung = 1'b1;
      done_valid = 1'b0;
      in_valid   = 1'b0;
      ksz = kq.size();
      csz = cq.size();
      exp_k = (ksz > 0) && order_ok(kq[0]) && (cmp_running() < NC);
      exp_x = 1'b0;
      if (csz > 0) begin
         xt = (c_kind[cq[0]] == 1) ? NC : NC + 1;
         exp_x = order_ok(cq[0]) && (owner[xt] < 0);
      end
      // completion choice uses the state before this edge
      ct = -1; cidx = -1;
      if ($urandom_range(99) < pct) begin
         int st = $urandom_range(NC + 1);
         for (int k = 0; k < NC + 2; k++) begin
            int t = (st + k) % (NC + 2);
            if (ct < 0 && owner[t] >= 0) begin ct = t; cidx = owner[t]; end
         end
      end
      // compute queue
      if (exp_k || cmp_go) begin
         checks++;
         if (exp_k != cmp_go) begin
            errors++;
            $display("FAIL R3 R4 R5 R6 R8 R9 compute go: actual %0b expected %0b (cycle %0d)",
                     cmp_go, exp_k, cyc);
         end else begin
            h = kq[0];
            checks++;
            if (int'(cmp_stream) != c_sid[h] || int'(cmp_tag) != low_free()) begin
               errors++;
               $display("FAIL R3 R6 compute stream/tag: actual %0d/%0d expected %0d/%0d",
                        cmp_stream, cmp_tag, c_sid[h], low_free());
            end
         end
         if (cmp_go && ksz > 0) begin
            h = kq.pop_front();
            c_st[h] = 1;
            if (int'(cmp_tag) < NC) owner[cmp_tag] = h;
         end
      end
      // copy queue
      if (exp_x || cpy_go) begin
         checks++;
         if (exp_x != cpy_go) begin
            errors++;
            $display("FAIL R3 R4 R5 R7 R8 R9 copy go: actual %0b expected %0b (cycle %0d)",
                     cpy_go, exp_x, cyc);
         end else begin
            h = cq[0];
            xt = (c_kind[h] == 1) ? NC : NC + 1;
            checks++;
            if (int'(cpy_stream) != c_sid[h] || int'(cpy_tag) != xt) begin
               errors++;
               $display("FAIL R3 R7 copy stream/tag: actual %0d/%0d expected %0d/%0d",
                        cpy_stream, cpy_tag, c_sid[h], xt);
            end
         end
         if (cpy_go && csz > 0) begin
            h = cq.pop_front();
            c_st[h] = 1;
            if (int'(cpy_tag) >= NC && int'(cpy_tag) < NC + 2) owner[cpy_tag] = h;
         end
      end
      if (ct >= 0) begin
         done_valid = 1'b1;
         done_tag   = 5'(ct);
         c_st[cidx] = 2;
         if (owner[ct] == cidx) owner[ct] = -1;
      end
      if (want) begin
         in_valid  = 1'b1;
         in_kind   = 2'(kind);
         in_stream = 5'(sid);
         #1;
         exp_rdy = (kind == 0) ? (ksz < QD) : (csz < QD);
         checks++;
         if (in_ready != exp_rdy) begin
            errors++;
            $display("FAIL R2 in_ready: actual %0b expected %0b (kind %0d)", in_ready, exp_rdy, kind);
         end
         if (in_ready && nlog < NLOG) begin
            c_sid[nlog] = sid; c_kind[nlog] = kind; c_st[nlog] = 0;
            if (kind == 0) kq.push_back(nlog); else cq.push_back(nlog);
            nlog++;
            took = 1'b1;
         end
      end
   endtask

   initial begin
      bit took;
      int kind, sid, pct;
      in_valid = 0; in_kind = 0; in_stream = 0; done_valid = 0; done_tag = 0;
      for (int t = 0; t < NC + 2; t++) owner[t] = -1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      for (int k = 0; k < 3; k++) begin
         in_kind = 2'(k);
         #1;
         checks++;
         if (in_ready !== 1'b1 || cmp_go !== 1'b0 || cpy_go !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: ready/cmp/cpy actual %0b%0b%0b expected 100",
                     in_ready, cmp_go, cpy_go);
         end
      end
      in_kind = 0;
      for (int p = 0; p < 6 && !hung; p++) begin
         case (p)
            0: pct = 8; 1: pct = 30; 2: pct = 40; 3: pct = 50; 4: pct = 40; default: pct = 25;
         endcase
         for (int n = 0; n < 60 && !hung; n++) begin
            case (p)
               0: begin kind = 0; sid = 1 + (n % 31); end
               1: begin kind = 1 + $urandom_range(1); sid = 1 + $urandom_range(2); end
               2: begin kind = $urandom_range(2); sid = $urandom_range(3); end
               3: begin kind = $urandom_range(2); sid = 5; end
               4: begin kind = $urandom_range(2); sid = $urandom_range(1); end
               default: begin kind = $urandom_range(2); sid = $urandom_range(NS - 1); end
            endcase
            took = 1'b0;
            while (!took && !hung) begin
               if ($urandom_range(99) < 70) step(1'b1, kind, sid, pct, took);
               else step(1'b0, 0, 0, pct, took);
            end
         end
         while (!all_done() && !hung) step(1'b0, 0, 0, (pct < 30) ? 30 : pct, took);
      end
      @(negedge clk);
      in_valid = 1'b0; done_valid = 1'b0;
      if (hung) begin
         errors++;
         $display("FAIL R8 watchdog expired: actual cycle %0d expected below %0d", cyc, LIMIT);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule